// File: doc/BRIEF.md
# Statistical Bin-Width Calibrator for a Delay-Line Time Digitizer

A tapped delay line does not split the clock period into equal slices; each tap has its own width. This block measures those widths by code density. Hits whose arrival is random with respect to the clock land in each bin in proportion to its width. The block collects a fixed number of such hits into a per-bin histogram, then walks once over the bins to build a table. The table holds the calibrated centre time of each bin, expressed as a binary fraction of one clock period.

A start pulse clears everything and arms collection. In calibrate mode, hits are counted until the in-range total reaches the sample target. The table pass then runs, and the done flag rises when it ends. In run mode, each raw code is translated through the table with one cycle of latency. Bypass mode, and run mode before any calibration has finished, return the raw code unchanged. The histogram and an out-of-range counter can be read back at any time.

Top module: `tdc_bin_cal`

## Requirements
- R1: After reset, cal_done_o and time_valid_o are 0, ovf_count_o is 0, and every histogram bin reads 0.
- R2: With mode_i 2'b00 or 2'b11 (bypass), a valid code gives time_valid_o=1 and time_o equal to the zero-extended raw code on the next cycle. This holds whether or not a calibration has finished.
- R3: In mode_i 2'b01 (calibrate), while collection is armed, each valid in-range code (below NUM_BINS) increments its own bin by one. Calibrate-mode hits never raise time_valid_o.
- R4: A valid code of NUM_BINS or above that arrives in calibrate mode while collecting increments ovf_count_o only. It touches no bin and does not count toward the sample target.
- R5: Bin counters and the overflow counter stop at 2^CNT_W-1 instead of wrapping.
- R6: Once SAMPLE_TARGET in-range hits have been counted, further hits change no counter. Hits given in any mode other than calibrate are never counted.
- R7: cal_done_o rises exactly NUM_BINS+1 cycles after the clock edge that records the final in-range hit.
- R8: Table entry k equals floor((2*C_k + H_k) * 2^FRAC_W / (2*SAMPLE_TARGET)), clamped to 2^FRAC_W-1. Here H_k is bin k's count and C_k is the sum of the counts of bins 0 to k-1.
- R9: With mode_i 2'b10 (run) and cal_done_o=1, a valid code gives table entry [code] on the next cycle, with time_valid_o=1. An out-of-range code gives all ones. In run mode with cal_done_o=0, the raw code is returned.
- R10: start_i clears all bins, the overflow counter, the sample total and cal_done_o (0 on the next cycle), and arms collection. A hit in the same cycle as start_i is dropped. Calibrate-mode hits before the first start are not counted.
- R11: hist_data_o shows the count of bin hist_addr_i one cycle after the address is applied. An out-of-range address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear and arm a new calibration |
| mode_i | input | 2 | 00/11 bypass, 01 calibrate, 10 run |
| code_valid_i | input | 1 | Raw code strobe |
| code_i | input | CODE_W | Raw tap code |
| hist_addr_i | input | CODE_W | Histogram read address |
| time_valid_o | output | 1 | Output time valid, one cycle after the strobe |
| time_o | output | max(FRAC_W,CODE_W) | Calibrated fraction or raw code |
| cal_done_o | output | 1 | Table built and in use |
| hist_data_o | output | CNT_W | Registered histogram read data |
| ovf_count_o | output | CNT_W | Out-of-range hit count |

## Verification
A bin counter that is wrong shows up in two places: on hist_data_o one cycle after that address is read, and, once the pass finishes, in every table entry from that bin upward, because the running sum carries the error forward. A wrong sample total or gating shows up as a shifted rise of cal_done_o, which the bench times to the exact cycle. A wrong step in the table pass, or a wrong lookup path, appears on time_o one cycle after the code is presented. For that reason all sixteen codes of a small configuration are swept after each calibration.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'b00,
    MODE_CAL  = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_BYP2 = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_BUILD,
    ST_DONE
  } state_e;
endpackage

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
  parameter int NUM_BINS      = 48,
  parameter int CODE_W        = 6,
  parameter int CNT_W         = 17,
  parameter int SAMPLE_TARGET = 50000,
  parameter int IDX_W         = 6,
  parameter int TOT_W         = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] rd_addr_i,
  input  logic [IDX_W-1:0]  bld_idx_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [CNT_W-1:0]  bld_cnt_o,
  output logic [CNT_W-1:0]  ovf_cnt_o,
  output logic              target_hit_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [CODE_W:0]   NB_L    = (CODE_W+1)'(NUM_BINS);
  localparam logic [TOT_W-1:0]  TGT_L   = TOT_W'(SAMPLE_TARGET);

  logic [CNT_W-1:0]    cnt_q [NUM_BINS];
  logic [NUM_BINS-1:0] inc_en;
  logic [CNT_W-1:0]    ovf_q;
  logic [TOT_W-1:0]    total_q;
  logic                in_range, rd_in_range;

  assign in_range    = {1'b0, code_i} < NB_L;
  assign rd_in_range = {1'b0, rd_addr_i} < NB_L;

  for (genvar g_bin = 0; g_bin < NUM_BINS; g_bin++) begin : g_inc
    assign inc_en[g_bin] = hit_i && in_range && (code_i == CODE_W'(g_bin))
                           && (cnt_q[g_bin] != CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BINS; i++) cnt_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < NUM_BINS; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_BINS; i++)
        if (inc_en[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= '0;
      total_q <= '0;
    end else if (clear_i) begin
      ovf_q   <= '0;
      total_q <= '0;
    end else if (hit_i) begin
      if (in_range)                total_q <= total_q + 1'b1;
      else if (ovf_q != CNT_MAX)   ovf_q   <= ovf_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rd_data_o <= '0;
    else if (rd_in_range) rd_data_o <= cnt_q[rd_addr_i[IDX_W-1:0]];
    else                  rd_data_o <= '0;
  end

  assign bld_cnt_o    = cnt_q[bld_idx_i];
  assign ovf_cnt_o    = ovf_q;
  assign target_hit_o = (total_q == TGT_L);

  AST_TOTAL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total_q <= TGT_L); // R6
  AST_NO_COUNT_AT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_hit_o && !clear_i) |=> $stable(total_q)); // R6
  AST_OVF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q == CNT_MAX && !clear_i) |=> ovf_q == CNT_MAX); // R5
endmodule

// File: rtl/tdc_cal_lut.sv
module tdc_cal_lut #(
  parameter int NUM_BINS      = 48,
  parameter int CODE_W        = 6,
  parameter int CNT_W         = 17,
  parameter int SAMPLE_TARGET = 50000,
  parameter int FRAC_W        = 8,
  parameter int IDX_W         = 6,
  parameter int TOT_W         = 16,
  parameter int TIME_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              build_i,
  input  logic [CNT_W-1:0]  bin_cnt_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o,
  input  logic              look_i,
  input  logic              use_lut_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              time_valid_o,
  output logic [TIME_W-1:0] time_o
);
  localparam int               NUM_W   = TOT_W + 2 + FRAC_W;
  localparam int               DEN     = 2 * SAMPLE_TARGET;
  localparam logic [NUM_W-1:0] FMAX    = NUM_W'((1 << FRAC_W) - 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_BINS - 1);
  localparam logic [CODE_W:0]  NB_L    = (CODE_W+1)'(NUM_BINS);

  logic [FRAC_W-1:0] lut_q [NUM_BINS];
  logic              active_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TOT_W-1:0]  cum_q;
  logic [NUM_W-1:0]  num, quot;
  logic [FRAC_W-1:0] centre;
  logic              in_range;

  // centre = (cum + cnt/2) / target, in 2^-FRAC_W units of a period
  assign num    = (NUM_W'({cum_q, 1'b0}) + NUM_W'(bin_cnt_i)) << FRAC_W;
  assign quot   = num / NUM_W'(DEN);
  assign centre = (quot > FMAX) ? FMAX[FRAC_W-1:0] : quot[FRAC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      cum_q    <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      cum_q    <= '0;
    end else if (build_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      cum_q    <= '0;
    end else if (active_q) begin
      cum_q <= cum_q + TOT_W'(bin_cnt_i);
      if (idx_q == LAST) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BINS; i++) lut_q[i] <= '0;
    end else if (active_q && !clear_i) begin
      lut_q[idx_q] <= centre;
    end
  end

  assign in_range = {1'b0, code_i} < NB_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_valid_o <= 1'b0;
      time_o       <= '0;
    end else begin
      time_valid_o <= look_i;
      if (look_i) begin
        if (!use_lut_i)    time_o <= TIME_W'(code_i);
        else if (in_range) time_o <= TIME_W'(lut_q[code_i[IDX_W-1:0]]);
        else               time_o <= TIME_W'(FMAX);
      end
    end
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;

  AST_LUT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q != '0) |-> centre >= lut_q[idx_q - 1'b1]); // R8
  AST_DONE_AFTER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(active_q && idx_q == LAST)); // R7
endmodule

// File: rtl/tdc_bin_cal.sv
module tdc_bin_cal
  import tdc_cal_pkg::*;
#(
  parameter int NUM_BINS      = 48,
  parameter int CODE_W        = 6,
  parameter int CNT_W         = 17,
  parameter int SAMPLE_TARGET = 50000,
  parameter int FRAC_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] hist_addr_i,
  output logic              time_valid_o,
  output logic [((FRAC_W > CODE_W) ? FRAC_W : CODE_W)-1:0] time_o,
  output logic              cal_done_o,
  output logic [CNT_W-1:0]  hist_data_o,
  output logic [CNT_W-1:0]  ovf_count_o
);
  localparam int IDX_W  = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;
  localparam int TOT_W  = $clog2(SAMPLE_TARGET + 1);
  localparam int TIME_W = (FRAC_W > CODE_W) ? FRAC_W : CODE_W;

  state_e           state_q;
  mode_e            mode;
  logic             accept, target_hit, build_go, bld_done, look;
  logic [IDX_W-1:0] bld_idx;
  logic [CNT_W-1:0] bld_cnt;

  assign mode     = mode_e'(mode_i);
  assign accept   = (state_q == ST_COLLECT) && !target_hit && code_valid_i
                    && (mode == MODE_CAL) && !start_i;
  assign build_go = (state_q == ST_COLLECT) && target_hit && !start_i;
  assign look     = code_valid_i && (mode != MODE_CAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ST_IDLE;
    else if (start_i) state_q <= ST_COLLECT;
    else begin
      case (state_q)
        ST_COLLECT: if (target_hit) state_q <= ST_BUILD;
        ST_BUILD:   if (bld_done)   state_q <= ST_DONE;
        default:    state_q <= state_q;
      endcase
    end
  end

  tdc_cal_hist #(
    .NUM_BINS(NUM_BINS), .CODE_W(CODE_W), .CNT_W(CNT_W),
    .SAMPLE_TARGET(SAMPLE_TARGET), .IDX_W(IDX_W), .TOT_W(TOT_W)
  ) u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start_i),
    .hit_i        (accept),
    .code_i       (code_i),
    .rd_addr_i    (hist_addr_i),
    .bld_idx_i    (bld_idx),
    .rd_data_o    (hist_data_o),
    .bld_cnt_o    (bld_cnt),
    .ovf_cnt_o    (ovf_count_o),
    .target_hit_o (target_hit)
  );

  tdc_cal_lut #(
    .NUM_BINS(NUM_BINS), .CODE_W(CODE_W), .CNT_W(CNT_W),
    .SAMPLE_TARGET(SAMPLE_TARGET), .FRAC_W(FRAC_W), .IDX_W(IDX_W),
    .TOT_W(TOT_W), .TIME_W(TIME_W)
  ) u_lut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start_i),
    .build_i      (build_go),
    .bin_cnt_i    (bld_cnt),
    .idx_o        (bld_idx),
    .done_o       (bld_done),
    .look_i       (look),
    .use_lut_i    (bld_done && (mode == MODE_RUN)),
    .code_i       (code_i),
    .time_valid_o (time_valid_o),
    .time_o       (time_o)
  );

  assign cal_done_o = bld_done;

  AST_NO_TIME_IN_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && mode == MODE_CAL) |=> !time_valid_o); // R3
  AST_LOOKUP_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look |=> time_valid_o); // R2
  AST_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !cal_done_o); // R10
  AST_DONE_AT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_done_o) |-> state_q == ST_BUILD); // R7
endmodule

// File: tb/tdc_bin_cal_tb_top.sv
module tdc_bin_cal_tb_top;
  localparam int NB  = 8;
  localparam int CW  = 4;
  localparam int HW  = 5;
  localparam int TGT = 40;
  localparam int FW  = 8;
  localparam int HMAX = (1 << HW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, valid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [CW-1:0] code = '0, haddr = '0;
  logic time_valid, cal_done;
  logic [FW-1:0] time_v;
  logic [HW-1:0] hdata, ovf;

  int checks = 0, fails = 0;
  int exp_h [NB];

  always #10 clk = ~clk;

  tdc_bin_cal #(.NUM_BINS(NB), .CODE_W(CW), .CNT_W(HW),
                .SAMPLE_TARGET(TGT), .FRAC_W(FW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .code_valid_i(valid), .code_i(code), .hist_addr_i(haddr),
    .time_valid_o(time_valid), .time_o(time_v), .cal_done_o(cal_done),
    .hist_data_o(hdata), .ovf_count_o(ovf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hit(input int c, input logic [1:0] m);
    code = CW'(c); mode = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic lookup(input int c, input logic [1:0] m, output int t, output int v);
    code = CW'(c); mode = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    t = int'(time_v); v = int'(time_valid);
  endtask

  task automatic read_hist(input int a, output int d);
    haddr = CW'(a);
    @(negedge clk);
    d = int'(hdata);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int exp_centre(input int k);
    int cum = 0;
    int v;
    for (int i = 0; i < k; i++) cum += exp_h[i];
    v = ((2 * cum + exp_h[k]) * (1 << FW)) / (2 * TGT);
    return (v > (1 << FW) - 1) ? (1 << FW) - 1 : v;
  endfunction

  task automatic check_hist(input string req);
    int d;
    for (int a = 0; a < (1 << CW); a++) begin
      read_hist(a, d);
      chk(d == ((a < NB) ? exp_h[a] : 0), req, d, (a < NB) ? exp_h[a] : 0);
    end
  endtask

  task automatic check_lut();
    int t, v, e;
    for (int c = 0; c < (1 << CW); c++) begin
      lookup(c, 2'b10, t, v);
      e = (c < NB) ? exp_centre(c) : (1 << FW) - 1;
      chk(t == e, "R8 R9 table value", t, e);
      chk(v == 1, "R9 valid", v, 1);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    chk(cal_done == 1'b0, req, int'(cal_done), 0);
    while (!cal_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == NB + 1, req, n, NB + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t, v, d;
    int cnt_a [NB] = '{5, 6, 4, 7, 5, 6, 7, 0};
    for (int i = 0; i < NB; i++) exp_h[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cal_done == 1'b0, "R1 done", int'(cal_done), 0);
    chk(time_valid == 1'b0, "R1 valid", int'(time_valid), 0);
    chk(ovf == '0, "R1 ovf", int'(ovf), 0);
    check_hist("R1 R11 hist after reset");

    // R2 bypass, both encodings
    for (int c = 0; c < (1 << CW); c++) begin
      lookup(c, (c % 2 == 0) ? 2'b00 : 2'b11, t, v);
      chk(t == c && v == 1, "R2 bypass", t, c);
    end
    // R9 run before calibration
    lookup(5, 2'b10, t, v);
    chk(t == 5 && v == 1, "R9 run uncalibrated", t, 5);

    // R10 calibrate hits before any start ignored
    hit(3, 2'b01); hit(3, 2'b01);
    chk(time_valid == 1'b0, "R3 no output in cal mode", int'(time_valid), 0);
    read_hist(3, d);
    chk(d == 0, "R10 before start", d, 0);

    // pattern A: interleaved, with out-of-range and run-mode hits
    pulse_start();
    for (int r = 0; r < 8; r++) begin
      for (int b = 0; b < NB; b++)
        if (r < cnt_a[b]) hit(b, 2'b01);
      if (r == 2) begin hit(9, 2'b01); hit(15, 2'b01); hit(4, 2'b10); hit(2, 2'b00); end
      if (r == 4) hit(8, 2'b01);
    end
    for (int i = 0; i < NB; i++) exp_h[i] = cnt_a[i];
    wait_done("R7 done latency A");
    hit(0, 2'b01); hit(0, 2'b01); hit(12, 2'b01);
    check_hist("R3 R6 R11 hist A");
    chk(ovf == HW'(3), "R4 ovf A", int'(ovf), 3);
    check_lut();
    lookup(3, 2'b00, t, v);
    chk(t == 3, "R2 bypass after cal", t, 3);

    // R10 clear on start
    pulse_start();
    chk(cal_done == 1'b0, "R10 done cleared", int'(cal_done), 0);
    for (int i = 0; i < NB; i++) exp_h[i] = 0;
    check_hist("R10 hist cleared");
    chk(ovf == '0, "R10 ovf cleared", int'(ovf), 0);
    lookup(3, 2'b10, t, v);
    chk(t == 3, "R9 raw after clear", t, 3);

    // pattern B: start with same-cycle hit, saturation
    start = 1'b1; code = CW'(5); mode = 2'b01; valid = 1'b1;
    @(negedge clk);
    start = 1'b0; valid = 1'b0;
    for (int i = 0; i < 35; i++) hit(2, 2'b01);
    for (int i = 0; i < 33; i++) hit(12, 2'b01);
    for (int i = 0; i < 5; i++) hit(6, 2'b01);
    exp_h[2] = HMAX; exp_h[6] = 5;
    wait_done("R7 done latency B");
    check_hist("R5 R10 hist B");
    chk(ovf == HW'(HMAX), "R5 ovf saturate", int'(ovf), HMAX);
    check_lut();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule